// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Match Scheduler

This block is the central arbiter for an N x N input-queued crossbar whose inputs keep one queue per output. Once per time slot the surrounding logic pulses `start` together with a request matrix. Bit `i*N+j` of that matrix says that input i holds at least one cell for output j. The block then runs a fixed number of request, grant and accept rounds, one clock cycle per round. It returns a one-to-one pairing of inputs to outputs: a matched flag for each input and the output index that input may send to.

Every output keeps a round-robin grant pointer and every input keeps a round-robin accept pointer. Only the first round of a slot moves the pointers. A grant pointer moves only when its grant is accepted. Under sustained load this rule pushes the outputs apart so that they favour different inputs, and the switch then settles into full matches. Later rounds reuse the pointers but do not move them, and they only add pairs among ports that are still free. The cell datapath, the crossbar and the queue storage belong to other blocks.

Top module: `xbar_match_sched`

## Requirements
- R1: After reset, all grant and accept pointers are 0, `done` is low and `match_vld` is all zero.
- R2: An input requests only the outputs whose request bit `i*N+j` is set, and only while that input is unmatched. Every reported pair (i, `match_idx` field i) has its request bit set.
- R3: An unmatched output that sees requests from unmatched inputs grants the first requesting input at or after its grant pointer, counting upward modulo N.
- R4: An unmatched input that receives grants accepts the first granting output at or after its accept pointer, modulo N. On a first-round accept, its accept pointer becomes (accepted output + 1) mod N.
- R5: In the first round, the grant pointer of output j becomes (granted input + 1) mod N if and only if that grant is accepted. Otherwise it keeps its value.
- R6: Rounds after the first change no pointer.
- R7: The result is one-to-one. No two matched inputs carry the same output index, and each input holds at most one output.
- R8: Each later round adds pairs only among inputs and outputs still free after the earlier rounds. With all requests set and all pointers at 0, one round yields 1 pair and two rounds yield 2.
- R9: `done` is a one-cycle pulse that rises ITERS clock cycles after the edge that samples `start`. `match_vld` and `match_idx` (field i at bits `i*IW +: IW`, IW = clog2 N) hold the result from then until the next accepted `start`.
- R10: The request matrix is sampled only on the edge that accepts `start`. A `start` that arrives while rounds are still in progress is ignored.
- R11: An all-zero request matrix yields no pairs and leaves every pointer unchanged.
- R12: Under continuous full load, every slot from slot N onward yields N pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a slot. Sampled together with `req_mat` |
| req_mat | input | N*N | Request matrix, bit i*N+j = input i has a cell for output j |
| done | output | 1 | One-cycle pulse when the slot's result is ready |
| match_vld | output | N | Bit i set when input i is matched |
| match_idx | output | N*IW | Output index for each input, field i at i*IW |

## Verification
The bench builds two copies with N = 4: one with two rounds per slot and one with a single round. Both copies get the same stimulus. Comparing them shows what the second round adds when the pointers start aligned after reset. It also shows that the one-round copy desynchronises under full load as well. Because N = 4 has wrap-around at both ends of every pointer, zero requests, single-column contention, random matrices and restarts during busy rounds all reach the pointer wrap within a few dozen slots.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;
   // step a round-robin position one place, wrapping at n
   function automatic int ring_step(input int pos, input int n);
      return (pos + 1 >= n) ? 0 : pos + 1;
   endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  cand,
   input  logic [IW-1:0] ptr,
   output logic          hit,
   output logic [IW-1:0] idx
);
   localparam bit POW2 = ((N & (N - 1)) == 0);

   generate
      if (N < 2) begin : g_bad_n
         $error("rr_pick needs N >= 2");
      end
      if (POW2) begin : g_wrap_mask
         // natural wrap of an IW-bit sum
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int k = N - 1; k >= 0; k--) begin
               logic [IW-1:0] p;
               p = ptr + IW'(k);
               if (cand[p]) begin
                  hit = 1'b1;
                  idx = p;
               end
            end
         end
      end else begin : g_wrap_cmp
         // explicit wrap for ring sizes that are not powers of two
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int k = N - 1; k >= 0; k--) begin
               int p;
               p = int'(ptr) + k;
               if (p >= N) p = p - N;
               if (cand[p]) begin
                  hit = 1'b1;
                  idx = IW'(p);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/grant_stage.sv
module grant_stage #(
   parameter int N  = 4,
   parameter int IW = $clog2(N)
) (
   input  logic [N*N-1:0]         req_q,
   input  logic [N-1:0]           in_free,
   input  logic [N-1:0]           out_free,
   input  logic [N-1:0][IW-1:0]   gptr,
   output logic [N-1:0]           g_hit,
   output logic [N-1:0][IW-1:0]   g_idx,
   output logic [N-1:0][N-1:0]    gnt
);
   generate
      for (genvar j = 0; j < N; j++) begin : g_out
         logic [N-1:0] col;
         logic         any;
         for (genvar i = 0; i < N; i++) begin : g_col
            assign col[i] = req_q[i*N+j] & in_free[i];
         end
         rr_pick #(.N(N), .IW(IW)) u_pick (
            .cand(col), .ptr(gptr[j]), .hit(any), .idx(g_idx[j])
         );
         assign g_hit[j] = any & out_free[j];
      end
      for (genvar i = 0; i < N; i++) begin : g_in
         for (genvar j = 0; j < N; j++) begin : g_bit
            assign gnt[i][j] = g_hit[j] && (g_idx[j] == IW'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/accept_stage.sv
module accept_stage #(
   parameter int N  = 4,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0][N-1:0]    gnt,
   input  logic [N-1:0]           in_free,
   input  logic [N-1:0][IW-1:0]   aptr,
   output logic [N-1:0]           a_hit,
   output logic [N-1:0][IW-1:0]   a_idx
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_in
         logic [N-1:0] row;
         assign row = gnt[i] & {N{in_free[i]}};
         rr_pick #(.N(N), .IW(IW)) u_pick (
            .cand(row), .ptr(aptr[i]), .hit(a_hit[i]), .idx(a_idx[i])
         );
      end
   endgenerate
endmodule

// File: rtl/xbar_match_sched.sv
module xbar_match_sched #(
   parameter int N     = 4,
   parameter int ITERS = (N > 2) ? $clog2(N) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [N*N-1:0]           req_mat,
   output logic                     done,
   output logic [N-1:0]             match_vld,
   output logic [N*$clog2(N)-1:0]   match_idx
);
   import xbar_sched_pkg::*;

   localparam int IW = $clog2(N);
   localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

   generate
      if (N < 2) begin : g_chk_n
         $error("xbar_match_sched needs N >= 2");
      end
      if (ITERS < 1 || ITERS > N) begin : g_chk_it
         $error("ITERS must lie in 1..N");
      end
   endgenerate

   logic                   busy, done_q;
   logic [CW-1:0]          iter;
   logic [N*N-1:0]         req_q;
   logic [N-1:0]           in_used, out_used;
   logic [N-1:0][IW-1:0]   gptr, aptr, midx;
   logic [N-1:0]           g_hit, a_hit, g_acc;
   logic [N-1:0][IW-1:0]   g_idx, a_idx;
   logic [N-1:0][N-1:0]    gnt;
   logic                   first_rnd;

   assign first_rnd = busy && (iter == '0);

   grant_stage #(.N(N), .IW(IW)) u_grant (
      .req_q(req_q), .in_free(~in_used), .out_free(~out_used),
      .gptr(gptr), .g_hit(g_hit), .g_idx(g_idx), .gnt(gnt)
   );

   accept_stage #(.N(N), .IW(IW)) u_accept (
      .gnt(gnt), .in_free(~in_used), .aptr(aptr),
      .a_hit(a_hit), .a_idx(a_idx)
   );

   // whether output j's grant was taken by the input it picked
   always_comb begin
      for (int j = 0; j < N; j++) begin
         g_acc[j] = 1'b0;
         for (int i = 0; i < N; i++)
            if (a_hit[i] && a_idx[i] == IW'(j)) g_acc[j] = 1'b1;
      end
   end

   // slot sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         iter   <= '0;
         done_q <= 1'b0;
         req_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               iter  <= '0;
               req_q <= req_mat;
            end
         end else if (iter == LAST) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
         end else begin
            iter <= iter + 1'b1;
         end
      end
   end

   // match accumulation and pointer state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_used  <= '0;
         out_used <= '0;
         midx     <= '0;
         gptr     <= '0;
         aptr     <= '0;
      end else if (!busy) begin
         if (start) begin
            in_used  <= '0;
            out_used <= '0;
            midx     <= '0;
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            if (a_hit[i]) begin
               in_used[i]         <= 1'b1;
               out_used[a_idx[i]] <= 1'b1;
               midx[i]            <= a_idx[i];
               if (first_rnd) begin
                  aptr[i]        <= IW'(ring_step(int'(a_idx[i]), N));
                  gptr[a_idx[i]] <= IW'(ring_step(i, N));
               end
            end
         end
      end
   end

   assign done      = done_q;
   assign match_vld = in_used;
   assign match_idx = midx;

   // ---------------- assertions ----------------
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(match_vld) && $stable(match_idx)));

   assert_ptr_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !first_rnd |=> ($stable(gptr) && $stable(aptr)));

   assert_zero_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (first_rnd && req_q == '0) |=> ($stable(gptr) && $stable(aptr) && match_vld == '0));

   generate
      for (genvar i = 0; i < N; i++) begin : g_chk_in
         assert_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (done && match_vld[i]) |-> req_q[i*N + int'(match_idx[i*IW +: IW])]);
         assert_acc_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (first_rnd && a_hit[i]) |=>
               aptr[i] == IW'(ring_step(int'($past(a_idx[i])), N)));
         for (genvar k = i + 1; k < N; k++) begin : g_pair
            assert_one_to_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
               !(match_vld[i] && match_vld[k] &&
                 match_idx[i*IW +: IW] == match_idx[k*IW +: IW]));
         end
      end
      for (genvar j = 0; j < N; j++) begin : g_chk_out
         assert_gptr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (first_rnd && !g_acc[j]) |=> $stable(gptr[j]));
      end
   endgenerate
endmodule

// File: tb/tb_xbar_match_sched.sv
module tb_xbar_match_sched;
   localparam int NP = 4;
   localparam int IWP = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [NP*NP-1:0] req = '0;
   logic [1:0] dn;
   logic [NP-1:0] vl [2];
   logic [NP*IWP-1:0] ix [2];

   int errors = 0, checks = 0, cyc = 0;
   int gp [2][NP], ap [2][NP];
   int ev [2][NP], ei [2][NP];
   int its [2] = '{2, 1};
   logic [NP*NP-1:0] lat_req;

   always #2.5 clk = ~clk;

   xbar_match_sched #(.N(NP), .ITERS(2)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .req_mat(req),
      .done(dn[0]), .match_vld(vl[0]), .match_idx(ix[0]));
   xbar_match_sched #(.N(NP), .ITERS(1)) dut_one (
      .clk(clk), .rst_n(rst_n), .start(start), .req_mat(req),
      .done(dn[1]), .match_vld(vl[1]), .match_idx(ix[1]));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference for one instance
   task automatic model(input int u, input logic [NP*NP-1:0] r);
      bit iu [NP], ou [NP];
      int g [NP];
      for (int i = 0; i < NP; i++) begin iu[i] = 0; ou[i] = 0; ev[u][i] = 0; ei[u][i] = 0; end
      for (int it = 0; it < its[u]; it++) begin
         for (int j = 0; j < NP; j++) begin
            g[j] = -1;
            if (!ou[j])
               for (int k = 0; k < NP; k++) begin
                  int i = (gp[u][j] + k) % NP;
                  if (g[j] < 0 && !iu[i] && r[i*NP+j]) g[j] = i;
               end
         end
         for (int i = 0; i < NP; i++) begin
            int pick = -1;
            if (!iu[i])
               for (int k = 0; k < NP; k++) begin
                  int j = (ap[u][i] + k) % NP;
                  if (pick < 0 && g[j] == i) pick = j;
               end
            if (pick >= 0) begin
               iu[i] = 1; ou[pick] = 1; ev[u][i] = 1; ei[u][i] = pick;
               if (it == 0) begin
                  ap[u][i] = (pick + 1) % NP;
                  gp[u][pick] = (i + 1) % NP;
               end
            end
         end
      end
   endtask

   function automatic int npairs(input int u);
      int c = 0;
      for (int i = 0; i < NP; i++) c += int'(vl[u][i]);
      return c;
   endfunction

   // one slot; optionally pulse start again while busy (R10)
   task automatic slot(input logic [NP*NP-1:0] r, input bit restart, input int want_pairs);
      @(negedge clk);
      start = 1'b1; req = r; lat_req = r;
      model(0, r); model(1, r);
      for (int k = 0; k <= 3; k++) begin
         @(negedge clk);
         start = (k == 0) && restart;
         req = restart ? ~r : r;
         for (int u = 0; u < 2; u++) begin
            chk(dn[u] == (k == its[u]), "R9 done timing", int'(dn[u]), int'(k == its[u]));
            if (k >= its[u]) begin
               int seen = 0;
               for (int i = 0; i < NP; i++) begin
                  int a = int'(ix[u][i*IWP +: IWP]);
                  chk(vl[u][i] == ev[u][i], "R3 R4 R5 R6 R8 R10 match flag", int'(vl[u][i]), ev[u][i]);
                  if (ev[u][i] != 0)
                     chk(a == ei[u][i], "R3 R4 R5 R6 R9 match index", a, ei[u][i]);
                  if (vl[u][i]) begin
                     chk(lat_req[i*NP+a] == 1'b1, "R2 pair not requested", a, i);
                     chk(((seen >> a) & 1) == 0, "R7 output reused", a, -1);
                     seen |= 1 << a;
                  end
               end
               if (want_pairs >= 0)
                  chk(npairs(u) == want_pairs, "R12 full-load pairs", npairs(u), want_pairs);
            end
         end
      end
      start = 1'b0;
   endtask

   initial begin : watchdog
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int u = 0; u < 2; u++)
         for (int i = 0; i < NP; i++) begin gp[u][i] = 0; ap[u][i] = 0; end
      repeat (3) @(negedge clk);
      for (int u = 0; u < 2; u++) begin
         chk(dn[u] == 1'b0, "R1 done after reset", int'(dn[u]), 0);
         chk(vl[u] == '0, "R1 no match after reset", int'(vl[u]), 0);
      end
      rst_n = 1'b1;

      // R8: first full-load slot from reset pointers
      slot('1, 1'b0, -1);
      chk(npairs(0) == 2, "R8 two rounds from reset", npairs(0), 2);
      chk(npairs(1) == 1, "R8 one round from reset", npairs(1), 1);
      // R12: continued full load, desynchronised from slot N on
      for (int s = 1; s < 12; s++) slot('1, 1'b0, (s >= NP) ? NP : -1);

      // R11: empty matrix, then full load must still give N pairs
      slot('0, 1'b0, 0);
      slot('1, 1'b0, NP);

      // contention on one output column: exactly one pair (R3)
      for (int s = 0; s < 5; s++) slot(16'h4444, 1'b0, 1);

      // R10: restart while busy must not disturb the slot
      slot(16'h8421, 1'b1, -1);
      slot(16'h1248, 1'b1, -1);

      // random matrices
      for (int s = 0; s < 40; s++) slot(NP*NP'($urandom), (s % 7) == 3, -1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule